// File: doc/BRIEF.md
# Programmable Flag Threshold Register Loader

This block keeps the two threshold values that a FIFO's programmable flags compare against: one that sets how close to empty the almost-empty flag trips, and one that sets how close to full the almost-full flag trips. It does not hold FIFO data and does not compute any flag. It only owns the thresholds and the ways of setting and inspecting them.

The level of the active-low load strobe while master reset is held picks two things at once. It picks the default thresholds (127 when low, 1023 when high). It also picks the only loading method that works until the next reset: word-wide loading over the input bus when low, bit-serial loading when high. After reset, the load strobe gates every programming and readback action. Readback always uses the parallel output bus, in either method, and is clocked by the read clock with its own word selector. The write and read clocks may be the same clock or separate clocks.

Top module: `flag_offset_prog`

## Requirements
- R1: If `ld_n` is 0 on the write-clock edges where `mrst` is 1, then after reset both `empty_ofs` and `full_ofs` read 0x07F, and the parallel loading method is the one in force.
- R2: If `ld_n` is 1 on the write-clock edges where `mrst` is 1, then after reset both thresholds read 0x3FF, and the serial loading method is the one in force.
- R3: In serial method, each write-clock edge with `ld_n`=0 and `sen_n`=0 stores `sdi` into one bit. The bit position runs through `empty_ofs` bits 0 to W-1, then `full_ofs` bits 0 to W-1, 2W bits in all. After that it returns to `empty_ofs` bit 0.
- R4: In serial method, an edge with `sen_n`=1 or `ld_n`=1 changes neither threshold and does not advance the serial bit position.
- R5: In parallel method, each write-clock edge with `ld_n`=0 and `wen_n`=0 loads `pdin` into a threshold. The first such edge after reset loads `empty_ofs`, the next loads `full_ofs`, and the sequence alternates from there.
- R6: The method not chosen at reset has no effect. In parallel method `sen_n` and `sdi` change nothing. In serial method `wen_n` and `pdin` change nothing.
- R7: Each read-clock edge with `ld_n`=0 and `ren_n`=0 puts a threshold on `pdout`. The first such edge after reset gives `empty_ofs`, the next gives `full_ofs`, and the sequence alternates. This works in both methods. At all other edges `pdout` holds its value, and it is 0 after reset.
- R8: With the two clocks coincident, a readback on the same edge as a parallel write returns the value the threshold held before that edge.
- R9: Master reset restores the defaults, the write-side word selector, the serial bit position and the readback selector, even when it arrives partway through a programming sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock; all threshold updates happen on its rising edge |
| rclk | input | 1 | Read clock; readback updates happen on its rising edge |
| mrst | input | 1 | Master reset, synchronous, active high, sampled by both clocks |
| ld_n | input | 1 | Load strobe, active low; during reset it selects defaults and method |
| sen_n | input | 1 | Serial shift enable, active low |
| sdi | input | 1 | Serial data bit |
| wen_n | input | 1 | Write enable, active low, used for parallel loading |
| ren_n | input | 1 | Read enable, active low, used for readback |
| pdin | input | 10 | Parallel threshold input word |
| empty_ofs | output | 10 | Current almost-empty threshold |
| full_ofs | output | 10 | Current almost-full threshold |
| pdout | output | 10 | Parallel readback word |

## Verification
Two functions can land on the same edge: a parallel threshold write on the write clock and a readback on the read clock. The bench drives both clocks from one source so the two always coincide, and it raises `wen_n`, `ren_n` and `ld_n` low together. The result must show the pre-edge threshold on `pdout` while the new word lands in the register. A sweep over all sixteen combinations of the four control levels, in each method, mixes ignored-method strokes into these collisions. The expected thresholds and readback words come from an arithmetic model kept in the bench.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
    parameter int unsigned OFS_W         = 10;
    parameter int unsigned DFLT_PARALLEL = 127;
    parameter int unsigned DFLT_SERIAL   = 1023;

    localparam int unsigned SER_BITS = 2 * OFS_W;
    localparam int unsigned SER_CW   = $clog2(SER_BITS);

    typedef logic [OFS_W-1:0] ofs_t;

    typedef enum logic {
        LOAD_PARALLEL = 1'b0,
        LOAD_SERIAL   = 1'b1
    } load_mode_e;

    typedef struct packed {
        ofs_t empty_ofs;
        ofs_t full_ofs;
    } ofs_pair_t;

    typedef struct packed {
        ofs_t empty_mask;
        ofs_t full_mask;
    } ofs_mask_t;

    function automatic ofs_t dflt_offset(load_mode_e m);
        return (m == LOAD_SERIAL) ? ofs_t'(DFLT_SERIAL) : ofs_t'(DFLT_PARALLEL);
    endfunction
endpackage

// File: rtl/ofs_serial_path.sv
module ofs_serial_path
    import ofs_pkg::*;
(
    input  logic      wclk,
    input  logic      mrst,
    input  logic      active,
    output ofs_mask_t mask
);
    logic [SER_CW-1:0] pos;

    always_ff @(posedge wclk) begin
        if (mrst) begin
            pos <= '0;
        end else if (active) begin
            pos <= (pos == SER_CW'(SER_BITS - 1)) ? '0 : pos + 1'b1;
        end
    end

    always_comb begin
        for (int i = 0; i < int'(OFS_W); i++) begin
            mask.empty_mask[i] = active && (pos == SER_CW'(i));
            mask.full_mask[i]  = active && (pos == SER_CW'(i + int'(OFS_W)));
        end
    end

    // R4: an idle edge leaves the bit position where it was
    p_pos_hold_r4: assert property (@(posedge wclk) disable iff (mrst)
        !active |=> $stable(pos));

    // R3: the position never leaves the 2W-bit range
    p_pos_range_r3: assert property (@(posedge wclk) disable iff (mrst)
        active |=> (pos < SER_CW'(SER_BITS)));
endmodule

// File: rtl/ofs_parallel_path.sv
module ofs_parallel_path
    import ofs_pkg::*;
(
    input  logic wclk,
    input  logic mrst,
    input  logic active,
    output logic we_empty,
    output logic we_full
);
    logic sel_full;

    always_ff @(posedge wclk) begin
        if (mrst) begin
            sel_full <= 1'b0;
        end else if (active) begin
            sel_full <= ~sel_full;
        end
    end

    assign we_empty = active && !sel_full;
    assign we_full  = active &&  sel_full;

    // R5: two consecutive word writes target different registers
    p_alternate_r5: assert property (@(posedge wclk) disable iff (mrst)
        (we_empty && active) |=> (active -> we_full));
endmodule

// File: rtl/ofs_regs.sv
module ofs_regs
    import ofs_pkg::*;
(
    input  logic       wclk,
    input  logic       mrst,
    input  load_mode_e rst_mode,
    input  load_mode_e mode,
    input  ofs_mask_t  ser_mask,
    input  logic       sdi,
    input  logic       we_empty,
    input  logic       we_full,
    input  ofs_t       pdin,
    output ofs_pair_t  regs
);
    ofs_pair_t nxt;
    ofs_t      dflt;

    assign dflt = dflt_offset(rst_mode);

    always_comb begin
        for (int i = 0; i < int'(OFS_W); i++) begin
            if (mrst) begin
                nxt.empty_ofs[i] = dflt[i];
                nxt.full_ofs[i]  = dflt[i];
            end else begin
                nxt.empty_ofs[i] = ser_mask.empty_mask[i] ? sdi :
                                   we_empty ? pdin[i] : regs.empty_ofs[i];
                nxt.full_ofs[i]  = ser_mask.full_mask[i] ? sdi :
                                   we_full ? pdin[i] : regs.full_ofs[i];
            end
        end
    end

    always_ff @(posedge wclk) begin
        regs <= nxt;
    end

    // R1 and R2: defaults follow the method latched at reset
    p_reset_default_r1: assert property (@(posedge wclk) disable iff (mrst)
        $fell(mrst) |-> (regs.empty_ofs == dflt_offset(mode)) &&
                        (regs.full_ofs  == dflt_offset(mode)));

    // R3: a serial edge flips at most one stored bit
    p_one_bit_r3: assert property (@(posedge wclk) disable iff (mrst)
        (ser_mask != '0) |=> ($countones(regs ^ $past(regs)) <= 1));

    // R4: no request, no change
    p_hold_r4: assert property (@(posedge wclk) disable iff (mrst)
        ((ser_mask == '0) && !we_empty && !we_full) |=> $stable(regs));

    // R5: a word write to the empty threshold leaves the full one alone
    p_word_empty_r5: assert property (@(posedge wclk) disable iff (mrst)
        we_empty |=> (regs.empty_ofs == $past(pdin)) && $stable(regs.full_ofs));
endmodule

// File: rtl/ofs_readback.sv
module ofs_readback
    import ofs_pkg::*;
(
    input  logic      rclk,
    input  logic      mrst,
    input  logic      rd_go,
    input  ofs_pair_t src,
    output ofs_t      pdout
);
    logic sel_full;

    always_ff @(posedge rclk) begin
        if (mrst) begin
            sel_full <= 1'b0;
            pdout    <= '0;
        end else if (rd_go) begin
            sel_full <= ~sel_full;
            pdout    <= sel_full ? src.full_ofs : src.empty_ofs;
        end
    end

    // R7: a readback word is always one of the two thresholds
    p_read_src_r7: assert property (@(posedge rclk) disable iff (mrst)
        rd_go |=> (pdout == $past(src.empty_ofs)) || (pdout == $past(src.full_ofs)));

    // R7: without a request the bus holds
    p_read_hold_r7: assert property (@(posedge rclk) disable iff (mrst)
        !rd_go |=> $stable(pdout));
endmodule

// File: rtl/flag_offset_prog.sv
module flag_offset_prog
    import ofs_pkg::*;
(
    input  logic             wclk,
    input  logic             rclk,
    input  logic             mrst,
    input  logic             ld_n,
    input  logic             sen_n,
    input  logic             sdi,
    input  logic             wen_n,
    input  logic             ren_n,
    input  logic [OFS_W-1:0] pdin,
    output logic [OFS_W-1:0] empty_ofs,
    output logic [OFS_W-1:0] full_ofs,
    output logic [OFS_W-1:0] pdout
);
    load_mode_e mode;
    load_mode_e rst_mode;
    ofs_mask_t  ser_mask;
    ofs_pair_t  regs;
    logic       ser_go;
    logic       par_go;
    logic       we_empty;
    logic       we_full;
    logic       rd_go;

    assign rst_mode = ld_n ? LOAD_SERIAL : LOAD_PARALLEL;

    always_ff @(posedge wclk) begin
        if (mrst) begin
            mode <= rst_mode;
        end
    end

    assign ser_go = (mode == LOAD_SERIAL)   && !ld_n && !sen_n;
    assign par_go = (mode == LOAD_PARALLEL) && !ld_n && !wen_n;
    assign rd_go  = !ld_n && !ren_n;

    ofs_serial_path u_serial (
        .wclk   (wclk),
        .mrst   (mrst),
        .active (ser_go),
        .mask   (ser_mask)
    );

    ofs_parallel_path u_parallel (
        .wclk     (wclk),
        .mrst     (mrst),
        .active   (par_go),
        .we_empty (we_empty),
        .we_full  (we_full)
    );

    ofs_regs u_regs (
        .wclk     (wclk),
        .mrst     (mrst),
        .rst_mode (rst_mode),
        .mode     (mode),
        .ser_mask (ser_mask),
        .sdi      (sdi),
        .we_empty (we_empty),
        .we_full  (we_full),
        .pdin     (pdin),
        .regs     (regs)
    );

    ofs_readback u_readback (
        .rclk  (rclk),
        .mrst  (mrst),
        .rd_go (rd_go),
        .src   (regs),
        .pdout (pdout)
    );

    assign empty_ofs = regs.empty_ofs;
    assign full_ofs  = regs.full_ofs;

    // R6: word strokes in serial method change nothing
    p_wen_ignored_r6: assert property (@(posedge wclk) disable iff (mrst)
        ((mode == LOAD_SERIAL) && sen_n) |=> ($stable(empty_ofs) && $stable(full_ofs)));

    // R6: serial strokes in parallel method change nothing
    p_sen_ignored_r6: assert property (@(posedge wclk) disable iff (mrst)
        ((mode == LOAD_PARALLEL) && (ld_n || wen_n)) |=> ($stable(empty_ofs) && $stable(full_ofs)));
endmodule

// File: tb/flag_offset_prog_bench.sv
module flag_offset_prog_bench;
    import ofs_pkg::*;

    localparam int W = OFS_W;

    logic clk = 1'b0;
    logic mrst, ld_n, sen_n, sdi, wen_n, ren_n;
    logic [W-1:0] pdin;
    logic [W-1:0] empty_ofs, full_ofs, pdout;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    logic [W-1:0] exp_e, exp_f, exp_pd;
    bit ser_mode, wsel, rsel;
    int spos;

    always #2 clk = ~clk;

    flag_offset_prog u_flag_offset_prog (
        .wclk(clk), .rclk(clk), .mrst(mrst), .ld_n(ld_n), .sen_n(sen_n),
        .sdi(sdi), .wen_n(wen_n), .ren_n(ren_n), .pdin(pdin),
        .empty_ofs(empty_ofs), .full_ofs(full_ofs), .pdout(pdout)
    );

    task automatic check(input string tag, input string what,
                         input logic [W-1:0] got, input logic [W-1:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(tag, "empty_ofs", empty_ofs, exp_e);
        check(tag, "full_ofs",  full_ofs,  exp_f);
        check(tag, "pdout",     pdout,     exp_pd);
    endtask

    task automatic do_reset(input logic l, input string tag);
        mrst = 1; ld_n = l; sen_n = 1; wen_n = 1; ren_n = 1; sdi = 0; pdin = '0;
        repeat (2) begin @(posedge clk); #1; end
        mrst = 0; ld_n = 1;
        ser_mode = l; wsel = 0; rsel = 0; spos = 0;
        exp_e = l ? W'(1023) : W'(127);
        exp_f = exp_e;
        exp_pd = '0;
        check_all(tag);
    endtask

    task automatic cycle(input logic l, input logic s, input logic sd, input logic w,
                         input logic r, input logic [W-1:0] d, input string tag);
        logic [W-1:0] old_e, old_f;
        ld_n = l; sen_n = s; sdi = sd; wen_n = w; ren_n = r; pdin = d;
        @(posedge clk); #1;
        old_e = exp_e; old_f = exp_f;
        if (!l && !r) begin
            exp_pd = rsel ? old_f : old_e;
            rsel = !rsel;
        end
        if (ser_mode && !l && !s) begin
            if (spos < W) exp_e[spos] = sd;
            else          exp_f[spos - W] = sd;
            spos = (spos + 1) % (2 * W);
        end
        if (!ser_mode && !l && !w) begin
            if (!wsel) exp_e = d;
            else       exp_f = d;
            wsel = !wsel;
        end
        check_all(tag);
        ld_n = 1; sen_n = 1; wen_n = 1; ren_n = 1;
    endtask

    task automatic shift_pair(input logic [W-1:0] e, input logic [W-1:0] f);
        for (int i = 0; i < 2 * W; i++)
            cycle(0, 0, (i < W) ? e[i] : f[i - W], 1, 1, '0, "R3");
        check("R3", "serial empty", empty_ofs, e);
        check("R3", "serial full",  full_ofs,  f);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        // R1: parallel method defaults
        do_reset(0, "R1");
        // R5: alternating word writes
        for (int k = 0; k < 16; k++) begin
            cycle(0, 1, 0, 0, 1, W'((k * 67) % 1024), "R5");
            cycle(0, 1, 0, 0, 1, W'((k * 131 + 5) % 1024), "R5");
        end
        // R7: readback alternates, then holds
        for (int k = 0; k < 4; k++) cycle(0, 1, 0, 1, 0, '0, "R7");
        for (int k = 0; k < 3; k++) cycle(0, 1, 0, 1, 1, '0, "R7");
        cycle(1, 1, 0, 1, 0, '0, "R7");
        // R8: write and readback on one edge
        for (int k = 0; k < 6; k++) cycle(0, 1, 0, 0, 0, W'(k * 171 + 3), "R8");
        // R6: serial strokes ignored in parallel method
        for (int k = 0; k < 8; k++) cycle(0, 0, k[0], 1, 1, '0, "R6");
        for (int i = 0; i < 64; i++)
            cycle(i[0], i[1], i[4], i[2], i[3], W'((i * 73) % 1024), "R6");
        // R9: reset mid-sequence returns selectors
        cycle(0, 1, 0, 0, 0, W'(300), "R9");
        do_reset(0, "R9");
        cycle(0, 1, 0, 0, 1, W'(555), "R9");
        cycle(0, 1, 0, 1, 0, '0, "R9");

        // R2: serial method defaults
        do_reset(1, "R2");
        shift_pair(W'(10'h2A5), W'(10'h15A));
        shift_pair(W'(0), W'(10'h3FF));
        shift_pair(W'(10'h3FF), W'(1));
        shift_pair(W'(10'h201), W'(10'h0F0));
        // R4: pauses keep position and contents
        for (int i = 0; i < 5; i++) cycle(0, 0, 1, 1, 1, '0, "R3");
        for (int k = 0; k < 3; k++) cycle(0, 1, 0, 1, 1, '0, "R4");
        for (int k = 0; k < 2; k++) cycle(1, 0, 0, 1, 1, '0, "R4");
        for (int i = 5; i < 2 * W; i++) cycle(0, 0, i[1], 1, 1, '0, "R3");
        // R6: word strokes ignored in serial method
        for (int k = 0; k < 6; k++) cycle(0, 1, 0, 0, 1, W'(k * 99), "R6");
        // R7: readback in serial method
        for (int k = 0; k < 4; k++) cycle(0, 1, 0, 1, 0, '0, "R7");
        for (int i = 0; i < 64; i++)
            cycle(i[0], i[1], i[5], i[2], i[3], W'((i * 37) % 1024), "R6");
        // R9: reset mid-shift restarts at empty bit 0
        for (int i = 0; i < 7; i++) cycle(0, 0, 0, 1, 1, '0, "R9");
        do_reset(1, "R9");
        shift_pair(W'(10'h1C3), W'(10'h2E7));
        cycle(0, 1, 0, 1, 0, '0, "R9");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule